// File: doc/BRIEF.md
# Clock-Generator Configuration Register Slave

This block is the configuration port of a clock-generator die. It is a two-wire serial slave (SMBus/I2C compatible, no clock stretching) that holds a small bank of 8-bit control registers. The register outputs steer the generator's output enables, stop masks, power-down drive modes, spread and test controls. One register reflects the frequency-select straps seen during reset, and one holds a fixed vendor and revision code.

The controller selects a transfer type with bit 7 of the command code. When that bit is set, a single register is written or read at the offset in bits 6:0. When it is clear, the transfer is a block transfer that starts at offset 0 and walks upward. A block write carries a byte count ahead of its data. A block read answers with a byte count, then the registers in order. SCL and SDA are oversampled on the system clock. The data line is open drain, with a separate input, output and pull-down enable.

Top module: `ctl_cfg_smbus_slave`

## Requirements
- R1: After reset the eight register bytes read FFh, F6h, FFh, 00h, 07h, 00h, {00011b, straps}, 28h for offsets 0 to 7, where the straps are strap_i sampled during reset.
- R2: The slave acknowledges only the 7-bit address 69h (bytes D2h for write, D3h for read). Any other address gets no acknowledge, and the rest of that transfer, data bytes included, is ignored.
- R3: A write with command bit 7 = 1 stores the next data byte at the offset in command bits 6:0, and every byte of that write is acknowledged.
- R4: A read with command bit 7 = 1, followed by a repeated start and the read address, returns the register at that offset MSB first.
- R5: A write with command bit 7 = 0 takes a byte count, then stores the data bytes at offsets 0, 1, 2 and upward. A stop after any complete byte leaves the registers not yet reached unchanged.
- R6: A read after a command with bit 7 = 0 returns the count 08h, then offsets 0 to 7 in ascending order, one per master acknowledge. A master not-acknowledge ends the transfer.
- R7: Bits 2:0 of offset 6 and all of offset 7 are read-only and keep their values through writes.
- R8: A write to offset 8 or higher is acknowledged and changes no register. A read from such an offset returns 00h.
- R9: A START or STOP seen in the middle of a byte discards the partial byte. The next transfer is handled normally.
- R10: The slave pulls SDA low only for acknowledge bits and read data zeros. Its pull-down enable changes only while SCL is low, and it is released after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while it is high |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_o | output | 1 | Data value driven when enabled (always 0, open drain) |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| strap_i | input | 3 | Frequency-select straps captured into offset 6 bits 2:0 |
| cfg_o | output | 64 | All register bytes, offset n at bits 8n+7:8n |

## Verification
The bench builds the block with its default parameters: address 69h, eight registers and a two-stage synchronizer. With eight registers a single block read covers the whole bank, including both read-only bytes, and offset 10h lies in the unmapped range. The two-stage synchronizer sets how much SCL low time the slave needs before it can change SDA. The bench runs SCL with five system clocks per quarter period, so acknowledge release and read-data setup are exercised close to that margin. The bench also aborts bytes partway through with STOP and with repeated START, and tries a foreign address.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  localparam int STRAP_W    = 3;
  localparam int STRAP_IDX  = 6;
  localparam int VENDOR_IDX = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_WDATA,
    ST_RDATA,
    ST_DONE
  } link_st_t;

  // value loaded into a register by reset
  function automatic logic [7:0] reset_value(input int idx, input logic [STRAP_W-1:0] strap);
    case (idx)
      0:       return 8'hFF;
      1:       return 8'hF6;
      2:       return 8'hFF;
      3:       return 8'h00;
      4:       return 8'h07;
      5:       return 8'h00;
      6:       return {5'b00011, strap};
      7:       return 8'h28;
      default: return 8'h00;
    endcase
  endfunction

  // bits a write may change
  function automatic logic [7:0] write_mask(input logic [6:0] idx);
    if (idx == 7'(STRAP_IDX))  return 8'hF8;
    if (idx == 7'(VENDOR_IDX)) return 8'h00;
    return 8'hFF;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  assign scl_d = scl_ff[STAGES-1];
  assign sda_d = sda_ff[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
    end else begin
      scl_ff[0] <= scl_i;
      sda_ff[0] <= sda_i;
      for (int i = 1; i < STAGES; i++) begin
        scl_ff[i] <= scl_ff[i-1];
        sda_ff[i] <= sda_ff[i-1];
      end
    end
  end

  // events registered together with the levels they describe
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_lvl  <= 1'b1;
      sda_lvl  <= 1'b1;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
      start_ev <= 1'b0;
      stop_ev  <= 1'b0;
    end else begin
      scl_lvl  <= scl_d;
      sda_lvl  <= sda_d;
      scl_rise <= scl_d & ~scl_lvl;
      scl_fall <= ~scl_d & scl_lvl;
      start_ev <= scl_d & scl_lvl & sda_lvl & ~sda_d;
      stop_ev  <= scl_d & scl_lvl & ~sda_lvl & sda_d;
    end
  end

endmodule

// File: rtl/smb_link_fsm.sv
module smb_link_fsm
  import ctlreg_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h69,
  parameter int         NREG  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_lvl,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_data,
  output logic       sda_drv,
  output logic [6:0] rd_idx,
  output logic       wr_en,
  output logic [6:0] wr_idx,
  output logic [7:0] wr_data
);

  localparam logic [7:0] CNT_BYTE = 8'(NREG);

  link_st_t   st;
  logic [3:0] bitn;
  logic [7:0] shreg;
  logic       tx, in_ack, ack_en, blk, cnt_pend;
  logic [6:0] ptr, ptr_inc;
  logic [7:0] rx_byte, tx_byte;
  logic       active;

  always_comb begin
    rx_byte = {shreg[6:0], sda_lvl};
    tx_byte = cnt_pend ? CNT_BYTE : rd_data;
    ptr_inc = (ptr == 7'h7F) ? ptr : ptr + 7'd1;
    active  = (st != ST_IDLE) && (st != ST_DONE);
  end

  assign rd_idx = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bitn     <= 4'd0;
      shreg    <= 8'h00;
      tx       <= 1'b0;
      in_ack   <= 1'b0;
      ack_en   <= 1'b0;
      blk      <= 1'b1;
      cnt_pend <= 1'b0;
      ptr      <= 7'd0;
      sda_drv  <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= 7'd0;
      wr_data  <= 8'h00;
    end else begin
      wr_en <= 1'b0;
      if (stop_ev || start_ev) begin
        st      <= stop_ev ? ST_IDLE : ST_ADDR;
        bitn    <= 4'd0;
        tx      <= 1'b0;
        in_ack  <= 1'b0;
        sda_drv <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (bitn < 4'd8) begin
            bitn <= bitn + 4'd1;
            if (!tx) begin
              shreg <= rx_byte;
              if (bitn == 4'd7) begin
                ack_en <= 1'b1;
                case (st)
                  ST_ADDR: begin
                    if (rx_byte[7:1] == ADDR7) begin
                      if (rx_byte[0]) begin
                        st       <= ST_RDATA;
                        cnt_pend <= blk;
                      end else begin
                        st <= ST_CMD;
                      end
                    end else begin
                      ack_en <= 1'b0;
                      st     <= ST_DONE;
                    end
                  end
                  ST_CMD: begin
                    blk <= ~rx_byte[7];
                    ptr <= rx_byte[7] ? rx_byte[6:0] : 7'd0;
                    st  <= rx_byte[7] ? ST_WDATA : ST_CNT;
                  end
                  ST_CNT: st <= ST_WDATA;
                  ST_WDATA: begin
                    wr_en   <= 1'b1;
                    wr_idx  <= ptr;
                    wr_data <= rx_byte;
                    ptr     <= ptr_inc;
                  end
                  default: ack_en <= 1'b0;
                endcase
              end
            end
          end else if (tx) begin
            // master acknowledge slot of a read byte
            if (!sda_lvl) begin
              if (cnt_pend) cnt_pend <= 1'b0;
              else          ptr      <= ptr_inc;
            end else begin
              st     <= ST_DONE;
              tx     <= 1'b0;
              in_ack <= 1'b0;
              bitn   <= 4'd0;
            end
          end
        end else if (scl_fall) begin
          if (bitn == 4'd8 && !in_ack) begin
            in_ack  <= 1'b1;
            sda_drv <= !tx && ack_en;
          end else if (bitn == 4'd8) begin
            in_ack <= 1'b0;
            bitn   <= 4'd0;
            if (st == ST_RDATA) begin
              tx      <= 1'b1;
              shreg   <= tx_byte;
              sda_drv <= ~tx_byte[7];
            end else begin
              tx      <= 1'b0;
              sda_drv <= 1'b0;
            end
          end else if (tx && bitn != 4'd0) begin
            sda_drv <= ~shreg[3'd7 - bitn[2:0]];
          end
        end
      end
    end
  end

  // R10
  sda_quiet_high_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_drv) |-> !scl_lvl);

  // R6
  tx_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    tx |-> (st == ST_RDATA));

  // R9
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (bitn == 4'd0 && !tx && st == ST_ADDR));

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import ctlreg_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wr_en,
  input  logic [6:0]         wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [6:0]         rd_idx,
  output logic [7:0]         rd_data,
  output logic [8*NREG-1:0]  cfg_flat_o
);

  localparam int         IW     = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [7:0] NREG_B = 8'(NREG);

  logic [7:0] regs [NREG];
  logic [7:0] wmask;
  logic       wr_hit, rd_hit;

  always_comb begin
    wmask  = write_mask(wr_idx);
    wr_hit = wr_en && ({1'b0, wr_idx} < NREG_B);
    rd_hit = {1'b0, rd_idx} < NREG_B;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= reset_value(i, strap_i);
    end else if (wr_hit) begin
      regs[wr_idx[IW-1:0]] <= (wr_data & wmask) | (regs[wr_idx[IW-1:0]] & ~wmask);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else     rd_data <= rd_hit ? regs[rd_idx[IW-1:0]] : 8'h00;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign cfg_flat_o[8*g +: 8] = regs[g];
  end

  // R8
  oob_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ({1'b0, wr_idx} >= NREG_B)) |=> $stable(cfg_flat_o));

  if (NREG > VENDOR_IDX) begin : g_ro_chk
    // R7
    vendor_ro_chk: assert property (@(posedge clk) disable iff (rst)
      $stable(cfg_flat_o[8*VENDOR_IDX +: 8]));
    // R7
    strap_ro_chk: assert property (@(posedge clk) disable iff (rst)
      $stable(cfg_flat_o[8*STRAP_IDX +: STRAP_W]));
  end

endmodule

// File: rtl/ctl_cfg_smbus_slave.sv
module ctl_cfg_smbus_slave
  import ctlreg_pkg::*;
#(
  parameter logic [6:0] ADDR7       = 7'h69,
  parameter int         NREG        = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_o,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [8*NREG-1:0]  cfg_o
);

  logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic [7:0] rd_data, wr_data;
  logic [6:0] rd_idx, wr_idx;
  logic       wr_en;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  smb_link_fsm #(.ADDR7(ADDR7), .NREG(NREG)) u_link (
    .clk      (clk),
    .rst      (rst),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rd_data  (rd_data),
    .sda_drv  (sda_oe_o),
    .rd_idx   (rd_idx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );

  cfg_regfile #(.NREG(NREG)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .strap_i    (strap_i),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .cfg_flat_o (cfg_o)
  );

  assign sda_o = 1'b0;

endmodule

// File: tb/ctl_cfg_smbus_slave_tb_top.sv
module ctl_cfg_smbus_slave_tb_top;

  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0]  strap = 3'b101;
  logic        sda_oe, sda_o;
  logic [63:0] cfg;
  wire         scl_line = scl_m;
  wire         sda_line = sda_m & ~sda_oe;

  ctl_cfg_smbus_slave dut_i (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_line),
    .sda_i    (sda_line),
    .sda_o    (sda_o),
    .sda_oe_o (sda_oe),
    .strap_i  (strap),
    .cfg_o    (cfg)
  );

  int n_chk = 0, n_fail = 0, viol = 0;
  logic [7:0] mdl [8] = '{8'hFF, 8'hF6, 8'hFF, 8'h00, 8'h07, 8'h00, 8'h1D, 8'h28};

  task automatic check_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] mon_byte;
  event       mon_ev;

  task automatic push_exp(logic [7:0] b, string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  initial forever begin
    @(mon_ev);
    if (exp_q.size() == 0) check_eq("R6", "unexpected read byte", int'(mon_byte), -1);
    else check_eq(tag_q.pop_front(), "read byte", int'(mon_byte), int'(exp_q.pop_front()));
  end

  // R10: pull-down may only move while SCL is low
  always @(sda_oe) if (!rst && scl_line) viol++;

  task automatic wq(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic wbit(logic b);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    b = sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic wbyte(logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
    ack = ~a;
  endtask

  task automatic rbyte(logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~mack);
    mon_byte = d;
    -> mon_ev;
  endtask

  task automatic byte_write(logic [6:0] off, logic [7:0] d, output logic ack);
    logic a1, a2, a3;
    bus_start();
    wbyte(8'hD2, a1);
    wbyte({1'b1, off}, a2);
    wbyte(d, a3);
    bus_stop();
    ack = a1 & a2 & a3;
  endtask

  task automatic byte_read(logic [6:0] off, logic [7:0] exp, string tag);
    logic a;
    logic [7:0] d;
    push_exp(exp, tag);
    bus_start();
    wbyte(8'hD2, a);
    wbyte({1'b1, off}, a);
    bus_rstart();
    wbyte(8'hD3, a);
    rbyte(1'b0, d);
    bus_stop();
  endtask

  function automatic logic [7:0] cfgb(int i);
    return cfg[8*i +: 8];
  endfunction

  initial begin
    logic ack;
    logic [7:0] d;
    wq(5);
    rst = 1'b0;
    wq(5);

    // R1: reset image and idle bus
    for (int i = 0; i < 8; i++) check_eq("R1", $sformatf("reset byte %0d", i), int'(cfgb(i)), int'(mdl[i]));
    check_eq("R10", "pull-down idle after reset", int'(sda_oe), 0);

    // R4: single read of offset 1
    byte_read(7'd1, mdl[1], "R4");

    // R3: single write of offset 2
    byte_write(7'd2, 8'h5A, ack);
    check_eq("R3", "write acked", int'(ack), 1);
    mdl[2] = 8'h5A;
    check_eq("R3", "offset 2 after write", int'(cfgb(2)), 8'h5A);
    byte_read(7'd2, 8'h5A, "R4");

    // R2: foreign address
    bus_start();
    wbyte({7'h50, 1'b0}, ack);
    check_eq("R2", "foreign address ack", int'(ack), 0);
    wbyte(8'h82, ack);
    check_eq("R2", "command after foreign address ack", int'(ack), 0);
    wbyte(8'h11, ack);
    bus_stop();
    check_eq("R2", "offset 2 untouched", int'(cfgb(2)), int'(mdl[2]));

    // R5: block write of three bytes
    bus_start();
    wbyte(8'hD2, ack);
    wbyte(8'h00, ack);
    wbyte(8'h03, ack);
    check_eq("R5", "count acked", int'(ack), 1);
    wbyte(8'hA1, ack);
    wbyte(8'hA2, ack);
    wbyte(8'hA3, ack);
    check_eq("R5", "last data acked", int'(ack), 1);
    bus_stop();
    mdl[0] = 8'hA1; mdl[1] = 8'hA2; mdl[2] = 8'hA3;
    for (int i = 0; i < 4; i++) check_eq("R5", $sformatf("block byte %0d", i), int'(cfgb(i)), int'(mdl[i]));

    // R5: block write stopped after one data byte
    bus_start();
    wbyte(8'hD2, ack);
    wbyte(8'h00, ack);
    wbyte(8'h05, ack);
    wbyte(8'h3C, ack);
    bus_stop();
    mdl[0] = 8'h3C;
    check_eq("R5", "early stop byte 0", int'(cfgb(0)), 8'h3C);
    check_eq("R5", "early stop byte 1 kept", int'(cfgb(1)), int'(mdl[1]));

    // R6: block read of the whole bank
    push_exp(8'h08, "R6");
    for (int i = 0; i < 8; i++) push_exp(mdl[i], "R6");
    bus_start();
    wbyte(8'hD2, ack);
    wbyte(8'h00, ack);
    bus_rstart();
    wbyte(8'hD3, ack);
    check_eq("R6", "read address acked", int'(ack), 1);
    for (int i = 0; i < 9; i++) rbyte(i < 8, d);
    bus_stop();
    check_eq("R6", "pull-down released after nack", int'(sda_oe), 0);

    // R7: read-only fields
    byte_write(7'd7, 8'hFF, ack);
    byte_write(7'd6, 8'h00, ack);
    mdl[6] = 8'h05;
    check_eq("R7", "offset 6 keeps straps", int'(cfgb(6)), 8'h05);
    check_eq("R7", "offset 7 unchanged", int'(cfgb(7)), 8'h28);
    byte_read(7'd6, 8'h05, "R7");
    byte_read(7'd7, 8'h28, "R7");

    // R8: unmapped offset
    byte_write(7'h10, 8'h77, ack);
    check_eq("R8", "unmapped write acked", int'(ack), 1);
    for (int i = 0; i < 8; i++) check_eq("R8", $sformatf("byte %0d after unmapped write", i), int'(cfgb(i)), int'(mdl[i]));
    byte_read(7'h10, 8'h00, "R8");

    // R9: stop in the middle of a byte, then a normal read
    bus_start();
    wbit(1'b1); wbit(1'b1); wbit(1'b0); wbit(1'b1);
    bus_stop();
    byte_read(7'd0, mdl[0], "R9");

    // R9: repeated start in the middle of a byte, then a write
    bus_start();
    wbit(1'b1); wbit(1'b0); wbit(1'b1);
    bus_rstart();
    wbyte(8'hD2, ack);
    check_eq("R9", "address after restart acked", int'(ack), 1);
    wbyte(8'h81, ack);
    wbyte(8'h99, ack);
    bus_stop();
    mdl[1] = 8'h99;
    check_eq("R9", "write after restart", int'(cfgb(1)), 8'h99);

    wq(10);
    check_eq("R10", "pull-down moves with SCL high", viol, 0);
    check_eq("R6", "scoreboard drained", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule